// File: doc/BRIEF.md
# Converter Result Reader on a Two-Wire Bus

This block is a read-only two-wire bus target that sits in front of a 10-bit successive-approximation converter. It has no register map. It samples the bus clock and data lines with the system clock and recognises Start and Stop conditions. It compares each address byte against a fixed four-bit device code followed by three strap bits. When a read address matches, the acknowledge of that address starts a conversion, and the result comes back as two bytes.

While the master keeps acknowledging, the block keeps converting and sends one fresh result pair after another. A write address is acknowledged and nothing else happens, so a master can use it to poll for the device. If a result is not ready when the first data bit is due, the block holds the clock line low (clock stretching) until the converter reports done. The converter sits behind a one-cycle start strobe and a done/result handshake. The block pulls both lines low through output enables, in open-drain style.

Top module: `adc_i2c_reader`

## Requirements
- R1: After reset, the block drives neither line low (`sda_oe`=0, `scl_oe`=0) and does not raise `conv_start`.
- R2: An address byte whose upper four bits are 1001 and whose next three bits equal `addr_sel` is acknowledged: SDA is held low during the ninth clock.
- R3: An address with a different device code or different strap bits is not acknowledged and starts no conversion. Every later byte is also left unacknowledged until a new Start or Stop, even a byte that would otherwise match.
- R4: A matching address with R/W bit (bit 0) = 1 produces exactly one `conv_start` pulse, issued during its acknowledge.
- R5: A matching address with R/W = 0 is acknowledged, starts no conversion, and leaves SDA released for all clocks that follow until the next Start or Stop.
- R6: The first data byte of each pair is 0000 followed by result bits 9..6, most significant bit first.
- R7: The second data byte of each pair is result bits 5..0 followed by two zero bits.
- R8: A master acknowledge (SDA low) after the second byte starts a new conversion and a further pair. A master not-acknowledge (SDA high) after the second byte ends the transfer, and no more conversions follow.
- R9: If the result is not ready when the first bit of a pair is due, SCL is held low until the converter reports done, and is then released. A result that is already ready causes no stretch.
- R10: A Start that arrives in the middle of an address, or after a completed write-address acknowledge, abandons the transfer in progress and begins address reception again.
- R11: Results at both ends of the range, 0x000 and 0x3FF, are returned in straight binary.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 3 | Strap bits compared against address bits 3..1 |
| scl_in | input | 1 | Sensed level of the bus clock line |
| sda_in | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | When 1, pulls the data line low |
| scl_oe | output | 1 | When 1, holds the clock line low (stretch) |
| conv_start | output | 1 | One-cycle strobe that starts a conversion |
| conv_done | input | 1 | One-cycle pulse from the converter when a result is valid |
| conv_result | input | 10 | Converter result, captured on `conv_done` |

## Verification
The hardest case to reach from the ports is a stretch in the middle of a streamed transfer, where a new conversion starts on the master's acknowledge and has to finish before the first bit of the next pair. The bench's converter model has a latency that each test sets. A slow setting forces SCL to be held low both at the first pair and after a master acknowledge, and a fast setting shows that no stretch occurs. Repeated Starts are placed inside an address byte and after a polling acknowledge. A mismatched address is followed by a byte that would match, to show that the block stays ignored until the next Start.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int RES_W    = 10;
    localparam int PIN_W    = 3;
    localparam int BYTE_W   = 8;
    localparam int HI_BITS  = RES_W - 6;
    localparam logic [3:0] DEV_CODE = 4'b1001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_DRV,
        ST_ACK_HOLD,
        ST_WAIT,
        ST_TX,
        ST_MACK
    } rd_state_t;

    typedef struct packed {
        logic scl_s;
        logic sda_s;
        logic scl_rise;
        logic scl_fall;
        logic start_det;
        logic stop_det;
    } bus_ev_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [PIN_W-1:0]  pins);
        return (b[7:4] == DEV_CODE) && (b[3:1] == pins);
    endfunction

    function automatic logic [BYTE_W-1:0] hi_byte(input logic [RES_W-1:0] r);
        return {{(BYTE_W-HI_BITS){1'b0}}, r[RES_W-1:6]};
    endfunction

    function automatic logic [BYTE_W-1:0] lo_byte(input logic [RES_W-1:0] r);
        return {r[5:0], 2'b00};
    endfunction

endpackage

// File: rtl/adc_rd_bus_sync.sv
module adc_rd_bus_sync
    import adc_rd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        ev.scl_s     = scl_pipe[STAGES-1];
        ev.sda_s     = sda_pipe[STAGES-1];
        ev.scl_rise  = ev.scl_s & ~scl_q;
        ev.scl_fall  = ~ev.scl_s & scl_q;
        ev.start_det = ev.scl_s & scl_q & sda_q & ~ev.sda_s;
        ev.stop_det  = ev.scl_s & scl_q & ~sda_q & ev.sda_s;
    end
endmodule

// File: rtl/adc_rd_conv_if.sv
module adc_rd_conv_if
    import adc_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             done,
    input  logic [RES_W-1:0] result,
    output logic             ready,
    output logic [RES_W-1:0] res_q
);
    logic busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            ready <= 1'b0;
            res_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            ready <= 1'b0;
        end else if (done && busy) begin
            busy  <= 1'b0;
            ready <= 1'b1;
            res_q <= result;
        end
    end

    // a result only becomes ready on a converter done pulse
    assert_ready_from_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(done));
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_ev_t          ev,
    input  logic [PIN_W-1:0] addr_sel,
    input  logic             ready,
    input  logic [RES_W-1:0] res_q,
    output logic             sda_oe,
    output logic             scl_oe,
    output logic             conv_start
);
    rd_state_t         state;
    logic [2:0]        bit_cnt;
    logic [BYTE_W-1:0] sh;
    logic              rw_q, lower_q, mack_q;

    always_ff @(posedge clk) begin
        conv_start <= 1'b0;
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            sh      <= '0;
            rw_q    <= 1'b0;
            lower_q <= 1'b0;
            mack_q  <= 1'b0;
        end else if (ev.stop_det) begin
            state <= ST_IDLE;
        end else if (ev.start_det) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ADDR: if (ev.scl_rise) begin
                    sh      <= {sh[6:0], ev.sda_s};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        if (addr_hit({sh[6:0], ev.sda_s}, addr_sel)) begin
                            rw_q  <= ev.sda_s;
                            state <= ST_ACK_DRV;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_DRV: if (ev.scl_fall) begin
                    state <= ST_ACK_HOLD;
                    if (rw_q) conv_start <= 1'b1;
                end
                ST_ACK_HOLD: if (ev.scl_fall) begin
                    lower_q <= 1'b0;
                    bit_cnt <= '0;
                    if (!rw_q) begin
                        state <= ST_IDLE;
                    end else if (ready) begin
                        sh    <= hi_byte(res_q);
                        state <= ST_TX;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: if (ready) begin
                    sh      <= hi_byte(res_q);
                    bit_cnt <= '0;
                    state   <= ST_TX;
                end
                ST_TX: if (ev.scl_fall) begin
                    if (bit_cnt == 3'd7) begin
                        state <= ST_MACK;
                    end else begin
                        sh      <= {sh[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 3'd1;
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        mack_q <= ~ev.sda_s;
                        if (!ev.sda_s && lower_q) conv_start <= 1'b1;
                    end
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        if (!mack_q) begin
                            state <= ST_IDLE;
                        end else if (!lower_q) begin
                            lower_q <= 1'b1;
                            sh      <= lo_byte(res_q);
                            state   <= ST_TX;
                        end else begin
                            lower_q <= 1'b0;
                            state   <= ST_WAIT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe = (state == ST_ACK_HOLD) || ((state == ST_TX) && !sh[7]);
    assign scl_oe = (state == ST_WAIT);

    // SDA drive may only move while the sampled clock is low
    assert_sda_quiet_high_R12: assert property (@(posedge clk) disable iff (rst)
        (ev.scl_s && $past(ev.scl_s)) |-> $stable(sda_oe));
    // a started conversion invalidates the previous result
    assert_start_clears_ready_R4: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !ready);
    // stretching ends once the result is ready
    assert_stretch_release_R9: assert property (@(posedge clk) disable iff (rst)
        (scl_oe && ready) |=> !scl_oe);
    // a write address never converts or stretches
    assert_write_no_conv_R5: assert property (@(posedge clk) disable iff (rst)
        (conv_start || scl_oe) |-> rw_q);
endmodule

// File: rtl/adc_i2c_reader.sv
module adc_i2c_reader
    import adc_rd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] addr_sel,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    output logic             scl_oe,
    output logic             conv_start,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result
);
    bus_ev_t          ev;
    logic             ready;
    logic [RES_W-1:0] res_q;

    adc_rd_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    adc_rd_conv_if u_conv (
        .clk(clk), .rst(rst), .start(conv_start), .done(conv_done),
        .result(conv_result), .ready(ready), .res_q(res_q)
    );

    adc_rd_ctrl u_ctrl (
        .clk(clk), .rst(rst), .ev(ev), .addr_sel(addr_sel), .ready(ready),
        .res_q(res_q), .sda_oe(sda_oe), .scl_oe(scl_oe), .conv_start(conv_start)
    );
endmodule

// File: tb/adc_i2c_reader_bench.sv
module adc_i2c_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr_sel = 3'b101;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       sda_oe, scl_oe, conv_start, conv_done = 1'b0;
    logic [9:0] conv_result = '0;
    logic       scl_line, sda_line;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_i2c_reader u_adc_i2c_reader (
        .clk(clk), .rst(rst), .addr_sel(addr_sel), .scl_in(scl_line),
        .sda_in(sda_line), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .conv_start(conv_start), .conv_done(conv_done), .conv_result(conv_result)
    );

    int checks = 0, fails = 0;
    int conv_starts = 0, conv_lat = 5;
    logic [9:0] plan_q[$];
    logic [7:0] exp_q[$], rx_q[$];
    string      tag_q[$];

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // behavioural converter with programmable latency
    int         lat_cnt = 0;
    logic       pend = 1'b0;
    logic [9:0] cur = '0;
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            conv_starts <= conv_starts + 1;
            lat_cnt     <= conv_lat;
            pend        <= 1'b1;
            cur         <= (plan_q.size() > 0) ? plan_q.pop_front() : 10'h1C3;
        end else if (pend) begin
            if (lat_cnt <= 1) begin
                conv_done   <= 1'b1;
                conv_result <= cur;
                pend        <= 1'b0;
            end else begin
                lat_cnt <= lat_cnt - 1;
            end
        end
    end

    // SDA drive must stay put while the clock line is high (R12)
    int   r12_viol = 0;
    logic p_scl = 1'b1, p_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_line && p_scl && (sda_oe != p_oe)) r12_viol++;
        p_scl = scl_line;
        p_oe  = sda_oe;
    end

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (rx_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = rx_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(g == e, t, g, e);
        end
    end

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; half();
        m_scl = 1'b1;
        while (!scl_line) @(negedge clk);
        half();
        m_sda = 1'b0; half();
        m_scl = 1'b0; half();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; half();
        m_scl = 1'b1;
        while (!scl_line) @(negedge clk);
        half();
        m_sda = 1'b1; half();
    endtask

    task automatic clock_bit(input logic b, output logic s, output int st);
        m_sda = b; half();
        m_scl = 1'b1;
        st = 0;
        @(negedge clk);
        while (!scl_line) begin st++; @(negedge clk); end
        repeat (H/2) @(negedge clk);
        s = sda_line;
        repeat (H/2) @(negedge clk);
        m_scl = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic s; int st;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s, st);
        clock_bit(1'b1, s, st);
        ack = !s;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b, output int st0);
        logic s; int st;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s, st);
            if (i == 7) st0 = st;
            b[i] = s;
        end
        clock_bit(!give_ack, s, st);
    endtask

    function automatic logic [7:0] up_b(input logic [9:0] v);
        return {4'b0000, v[9:6]};
    endfunction
    function automatic logic [7:0] lo_b(input logic [9:0] v);
        return {v[5:0], 2'b00};
    endfunction

    // driver: full read transfer of one or two result pairs
    task automatic read_xfer(input int pairs, input logic [9:0] v0, input logic [9:0] v1,
                             input int lat, input string tag, output int st_a, output int st_b);
        logic ack; logic [7:0] b; int st;
        conv_lat = lat;
        plan_q.push_back(v0);
        if (pairs > 1) plan_q.push_back(v1);
        exp_q.push_back(up_b(v0)); tag_q.push_back({"R6 ", tag});
        exp_q.push_back(lo_b(v0)); tag_q.push_back({"R7 ", tag});
        if (pairs > 1) begin
            exp_q.push_back(up_b(v1)); tag_q.push_back({"R6/R8 ", tag});
            exp_q.push_back(lo_b(v1)); tag_q.push_back({"R7/R8 ", tag});
        end
        bus_start();
        write_byte({4'b1001, addr_sel, 1'b1}, ack);
        check(ack, "R2 read address ack", ack, 1);
        st_b = 0;
        for (int p = 0; p < pairs; p++) begin
            read_byte(1'b1, b, st);
            if (p == 0) st_a = st; else st_b = st;
            rx_q.push_back(b);
            read_byte(p < pairs - 1, b, st);
            rx_q.push_back(b);
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic ack; int sa, sb, c0; logic s; int st;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!sda_oe, "R1 sda_oe after reset", sda_oe, 0);
        check(!scl_oe, "R1 scl_oe after reset", scl_oe, 0);
        check(!conv_start, "R1 conv_start after reset", conv_start, 0);
        half();

        // single pair, fast converter: one conversion, no stretch
        c0 = conv_starts;
        read_xfer(1, 10'h2B5, 10'h0, 5, "single pair", sa, sb);
        repeat (300) @(negedge clk);
        check(conv_starts - c0 == 1, "R4 one conversion per read address", conv_starts - c0, 1);
        check(sa == 0, "R9 no stretch when result ready", sa, 0);

        // streamed pairs with a slow converter: stretch on both pairs, range ends
        c0 = conv_starts;
        read_xfer(2, 10'h000, 10'h3FF, 200, "R11 range ends", sa, sb);
        repeat (300) @(negedge clk);
        check(conv_starts - c0 == 2, "R8 master ack streams exactly one more conversion", conv_starts - c0, 2);
        check(sa > 0, "R9 stretch on first pair", sa, 1);
        check(sb > 0, "R9 stretch after master ack", sb, 1);

        // write address polling
        c0 = conv_starts;
        bus_start();
        write_byte({4'b1001, addr_sel, 1'b0}, ack);
        check(ack, "R2 write address ack", ack, 1);
        write_byte(8'h00, ack);
        check(!ack, "R5 bus released after poll", ack, 0);
        bus_stop();
        check(conv_starts == c0, "R5 no conversion on write", conv_starts - c0, 0);

        // mismatched strap bits, then a byte that would match
        c0 = conv_starts;
        bus_start();
        write_byte({4'b1001, ~addr_sel, 1'b1}, ack);
        check(!ack, "R3 wrong strap bits not acked", ack, 0);
        write_byte({4'b1001, addr_sel, 1'b1}, ack);
        check(!ack, "R3 ignored until next start", ack, 0);
        bus_stop();
        bus_start();
        write_byte({4'b1011, addr_sel, 1'b1}, ack);
        check(!ack, "R3 wrong device code not acked", ack, 0);
        bus_stop();
        check(conv_starts == c0, "R3 no conversion on mismatch", conv_starts - c0, 0);

        // repeated start inside an address byte
        bus_start();
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s, st);
        c0 = conv_starts;
        conv_lat = 5;
        plan_q.push_back(10'h155);
        exp_q.push_back(up_b(10'h155)); tag_q.push_back("R10 after restart");
        exp_q.push_back(lo_b(10'h155)); tag_q.push_back("R10 after restart");
        bus_start();
        write_byte({4'b1001, addr_sel, 1'b1}, ack);
        check(ack, "R10 address after mid-byte restart", ack, 1);
        begin
            logic [7:0] b;
            read_byte(1'b1, b, st); rx_q.push_back(b);
            read_byte(1'b0, b, st); rx_q.push_back(b);
        end
        bus_stop();

        // repeated start after a poll acknowledge, new strap value
        addr_sel = 3'b010;
        half();
        bus_start();
        write_byte({4'b1001, addr_sel, 1'b0}, ack);
        check(ack, "R10 poll before restart", ack, 1);
        read_xfer(1, 10'h0C7, 10'h0, 40, "R10 restart after poll", sa, sb);

        repeat (500) @(negedge clk);
        check(exp_q.size() == 0, "R6 all bytes received", exp_q.size(), 0);
        check(r12_viol == 0, "R12 SDA stable while SCL high", r12_viol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule